// File: doc/BRIEF.md
# Clock Output Gating and Lock Indicator

This block sits between two synthesized clock sources and the pins of a clock adapter. For each of the two clock channels it receives the channel's on/off control, a select that divides the clock by eight, and the channel's lock flag. It produces each channel's clock either unchanged or divided by eight, with a 50% duty cycle. Each output, and the 8 kHz sync output as well, is either driven or left high-impedance. A single lock output summarises the channels that are switched on.

The synthesized clocks are treated as level signals that are sampled by the block's system clock, which runs well above them. Every output is registered. Each tri-state pin appears as a data bit plus an output-enable bit. A high-impedance pin therefore shows as an enable of 0, and its data bit is then held at 0. The five gating controls come as one field from a separate control interface: bit 0 divides channel 1 by eight, bit 1 divides channel 2 by eight, bit 2 enables the second clock pin, bit 3 enables the first clock pin and bit 4 enables the sync pin.

Top module: `clkout_gate`

## Requirements
- R1: While reset is asserted, all three output enables, both clock data outputs, the sync data output and the lock output are 0, whatever the inputs are.
- R2: When both channels are switched on, the lock output is 1 one cycle after both lock flags are 1, and 0 one cycle after either flag is 0.
- R3: When exactly one channel is switched on, the lock output equals that channel's lock flag one cycle earlier, and the other flag has no effect.
- R4: When neither channel is switched on, the lock output is 0 one cycle later.
- R5: With its divide select at 0 and its channel switched on, a clock data output equals that channel's source level one cycle earlier. This needs the pin enable to be 1.
- R6: With its divide select at 1, a clock data output starts at 0 and toggles on every fourth rising edge of the source that the block samples. The result has a period of eight source periods and a 50% duty cycle.
- R7: A change of a channel's divide select, or of its on/off control, restarts that channel's divider. A divided output is 0 one cycle later, and counting starts again from zero rising edges.
- R8: Field bit 3 drives the first clock pin's enable, bit 2 the second clock pin's enable and bit 4 the sync pin's enable, each one cycle later. An enable of 0 forces that pin's data bit to 0.
- R9: When a channel is switched off, its clock data output is 0 one cycle later.
- R10: When sync is enabled, the sync data output equals the 8 kHz sync input one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_cfg | input | 5 | Gating field: bit0 ch1 divide, bit1 ch2 divide, bit2 pin-2 enable, bit3 pin-1 enable, bit4 sync enable |
| ch1_on | input | 1 | Channel 1 switched on |
| ch2_on | input | 1 | Channel 2 switched on |
| ch1_src | input | 1 | Channel 1 synthesized clock level |
| ch2_src | input | 1 | Channel 2 synthesized clock level |
| ch1_locked | input | 1 | Channel 1 lock flag |
| ch2_locked | input | 1 | Channel 2 lock flag |
| sync_in | input | 1 | 8 kHz sync level |
| clk1_dat | output | 1 | First clock pin data |
| clk1_oe | output | 1 | First clock pin output enable |
| clk2_dat | output | 1 | Second clock pin data |
| clk2_oe | output | 1 | Second clock pin output enable |
| sync_dat | output | 1 | Sync pin data |
| sync_oe | output | 1 | Sync pin output enable |
| lock_out | output | 1 | Combined lock status |

## Verification
A stale divider count or a missed restart shows as a divided clock edge that comes early or late. It appears within four source rising edges of the disturbance, so it can be seen within one half period of the divided clock. A wrong recorded select or on/off state either misses the forced low output on the cycle after a change, or restarts the divider on a cycle with no change. Either fault is visible one cycle later. Lock and enable faults are visible one cycle after the input that should have moved them, so the bench compares every output against its model on every cycle.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

    // Gating field, bit 4 down to bit 0
    typedef struct packed {
        logic sync_en;   // bit4
        logic pin1_en;   // bit3
        logic pin2_en;   // bit2
        logic ch2_div;   // bit1
        logic ch1_div;   // bit0
    } out_cfg_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/clkout_gate_div.sv
module clkout_gate_div #(
    parameter int DIV_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_on,
    input  logic div_sel,
    input  logic src,
    output logic clk_out
);
    localparam int HALF  = DIV_RATIO / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic             src;
        logic             sel;
        logic             on;
        logic [CNT_W-1:0] cnt;
        logic             div;
        logic             out;
    } div_state_t;

    div_state_t st_d, st_q;
    logic rise, restart;

    always_comb begin
        st_d    = st_q;
        rise    = src & ~st_q.src;
        restart = (div_sel != st_q.sel) || (ch_on != st_q.on);
        st_d.src = src;
        st_d.sel = div_sel;
        st_d.on  = ch_on;
        if (restart || !ch_on) begin
            st_d.cnt = '0;
            st_d.div = 1'b0;
        end else if (rise) begin
            if (st_q.cnt == CNT_W'(HALF - 1)) begin
                st_d.cnt = '0;
                st_d.div = ~st_q.div;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.out = ch_on ? (div_sel ? st_d.div : src) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out = st_q.out;

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_on && !div_sel) |=> (clk_out == $past(src)));  // R5
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_on && div_sel && !restart && !rise) |=> $stable(clk_out));  // R6
    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_on && div_sel && restart) |=> !clk_out);  // R7
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_on |=> !clk_out);  // R9
endmodule

// File: rtl/clkout_gate_lock.sv
module clkout_gate_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic on1,
    input  logic on2,
    input  logic lk1,
    input  logic lk2,
    output logic lock_out
);
    typedef struct packed {
        logic lock;
    } lock_state_t;

    lock_state_t ls_d, ls_q;

    always_comb begin
        ls_d      = ls_q;
        ls_d.lock = (on1 | on2) & (~on1 | lk1) & (~on2 | lk2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ls_q <= '0;
        else        ls_q <= ls_d;
    end

    assign lock_out = ls_q.lock;

    AST_LOCK_BOTH_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (on1 && on2 && !(lk1 && lk2)) |=> !lock_out);  // R2
    AST_LOCK_BOTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (on1 && on2 && lk1 && lk2) |=> lock_out);  // R2
    AST_LOCK_ONLY1: assert property (@(posedge clk) disable iff (!rst_n)
        (on1 && !on2) |=> (lock_out == $past(lk1)));  // R3
    AST_LOCK_ONLY2: assert property (@(posedge clk) disable iff (!rst_n)
        (on2 && !on1) |=> (lock_out == $past(lk2)));  // R3
    AST_LOCK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(on1 || on2) |=> !lock_out);  // R4
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
    import clkout_gate_pkg::*;
#(
    parameter int DIV_RATIO = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] out_cfg,
    input  logic       ch1_on,
    input  logic       ch2_on,
    input  logic       ch1_src,
    input  logic       ch2_src,
    input  logic       ch1_locked,
    input  logic       ch2_locked,
    input  logic       sync_in,
    output logic       clk1_dat,
    output logic       clk1_oe,
    output logic       clk2_dat,
    output logic       clk2_oe,
    output logic       sync_dat,
    output logic       sync_oe
    ,
    output logic       lock_out
);
    typedef struct packed {
        logic pin1_oe;
        logic pin2_oe;
        logic sync_oe;
        logic sync_v;
    } pin_state_t;

    out_cfg_t   cfg;
    pin_state_t pin_d, pin_q;
    logic [NUM_CH-1:0] ch_on_v, ch_src_v, ch_div_v, ch_out_v;

    assign cfg      = out_cfg_t'(out_cfg);
    assign ch_on_v  = {ch2_on, ch1_on};
    assign ch_src_v = {ch2_src, ch1_src};
    assign ch_div_v = {cfg.ch2_div, cfg.ch1_div};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clkout_gate_div #(.DIV_RATIO(DIV_RATIO)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .ch_on   (ch_on_v[g]),
            .div_sel (ch_div_v[g]),
            .src     (ch_src_v[g]),
            .clk_out (ch_out_v[g])
        );
    end

    clkout_gate_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .on1      (ch1_on),
        .on2      (ch2_on),
        .lk1      (ch1_locked),
        .lk2      (ch2_locked),
        .lock_out (lock_out)
    );

    always_comb begin
        pin_d         = pin_q;
        pin_d.pin1_oe = cfg.pin1_en;
        pin_d.pin2_oe = cfg.pin2_en;
        pin_d.sync_oe = cfg.sync_en;
        pin_d.sync_v  = cfg.sync_en & sync_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign clk1_oe  = pin_q.pin1_oe;
    assign clk2_oe  = pin_q.pin2_oe;
    assign sync_oe  = pin_q.sync_oe;
    assign sync_dat = pin_q.sync_v;
    assign clk1_dat = ch_out_v[0] & pin_q.pin1_oe;
    assign clk2_dat = ch_out_v[1] & pin_q.pin2_oe;

    AST_PIN1_ON: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg[3] |=> clk1_oe);  // R8
    AST_PIN1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_cfg[3] |=> (!clk1_oe && !clk1_dat));  // R8
    AST_PIN2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_cfg[2] |=> (!clk2_oe && !clk2_dat));  // R8
    AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_cfg[4] |=> (!sync_oe && !sync_dat));  // R8
    AST_SYNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg[4] |=> (sync_dat == $past(sync_in)));  // R10
endmodule

// File: tb/clkout_gate_bench.sv
module clkout_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] out_cfg = 5'h1F;
    logic       ch1_on = 1'b1, ch2_on = 1'b1;
    logic       ch1_src = 1'b0, ch2_src = 1'b0;
    logic       ch1_locked = 1'b1, ch2_locked = 1'b1;
    logic       sync_in = 1'b0;
    logic       clk1_dat, clk1_oe, clk2_dat, clk2_oe, sync_dat, sync_oe, lock_out;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    // behavioural model state
    int m_psrc[2], m_psel[2], m_pon[2], m_edges[2], m_out[2];
    int m_oe1, m_oe2, m_oes, m_sync, m_lock;

    clkout_gate u_clkout_gate (
        .clk(clk), .rst_n(rst_n), .out_cfg(out_cfg),
        .ch1_on(ch1_on), .ch2_on(ch2_on), .ch1_src(ch1_src), .ch2_src(ch2_src),
        .ch1_locked(ch1_locked), .ch2_locked(ch2_locked), .sync_in(sync_in),
        .clk1_dat(clk1_dat), .clk1_oe(clk1_oe), .clk2_dat(clk2_dat), .clk2_oe(clk2_oe),
        .sync_dat(sync_dat), .sync_oe(sync_oe), .lock_out(lock_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_psrc[i] = 0; m_psel[i] = 0; m_pon[i] = 0; m_edges[i] = 0; m_out[i] = 0;
            end
            m_oe1 = 0; m_oe2 = 0; m_oes = 0; m_sync = 0; m_lock = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                int s, sel, on;
                s   = (i == 0) ? int'(ch1_src) : int'(ch2_src);
                sel = int'(out_cfg[i]);
                on  = (i == 0) ? int'(ch1_on) : int'(ch2_on);
                if (sel != m_psel[i] || on != m_pon[i] || on == 0) m_edges[i] = 0;
                else if (s == 1 && m_psrc[i] == 0) m_edges[i]++;
                m_psrc[i] = s; m_psel[i] = sel; m_pon[i] = on;
                m_out[i] = (on == 0) ? 0 : (sel != 0 ? (m_edges[i] / 4) % 2 : s);
            end
            m_oe1 = out_cfg[3]; m_oe2 = out_cfg[2]; m_oes = out_cfg[4];
            m_sync = out_cfg[4] & sync_in;
            if (!ch1_on && !ch2_on) m_lock = 0;
            else m_lock = (!ch1_on || ch1_locked) && (!ch2_on || ch2_locked);
        end
    end

    // compare on every falling edge, then advance the modelled clock sources
    int c1 = 0, c2 = 0, cs = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(clk1_oe, m_oe1, "R8", "clk1_oe");
            check(clk2_oe, m_oe2, "R8", "clk2_oe");
            check(sync_oe, m_oes, "R8", "sync_oe");
            check(sync_dat, m_sync, "R10", "sync_dat");
            check(clk1_dat, m_out[0] & m_oe1, !ch1_on ? "R9" : (out_cfg[0] ? "R6" : "R5"), "clk1_dat");
            check(clk2_dat, m_out[1] & m_oe2, !ch2_on ? "R9" : (out_cfg[1] ? "R6" : "R5"), "clk2_dat");
            check(lock_out, m_lock, (!ch1_on && !ch2_on) ? "R4" : ((ch1_on && ch2_on) ? "R2" : "R3"), "lock_out");
        end
        c1++; if (c1 == 3)  begin c1 = 0; ch1_src = ~ch1_src; end
        c2++; if (c2 == 5)  begin c2 = 0; ch2_src = ~ch2_src; end
        cs++; if (cs == 40) begin cs = 0; sync_in = ~sync_in; end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    initial begin
        // R1: reset dominates every input
        repeat (4) @(negedge clk);
        check(clk1_oe, 0, "R1", "clk1_oe in reset");
        check(clk2_oe, 0, "R1", "clk2_oe in reset");
        check(sync_oe, 0, "R1", "sync_oe in reset");
        check(clk1_dat | clk2_dat | sync_dat, 0, "R1", "data in reset");
        check(lock_out, 0, "R1", "lock in reset");
        out_cfg = 5'b01000; ch2_on = 1'b0; ch1_locked = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        // only channel 1, pass-through; other lock flag ignored (R3)
        run(100); ch1_locked = 1'b1; ch2_locked = 1'b0;
        run(100);
        // channel 1 divided (R6)
        out_cfg = 5'b01001; run(300);
        // both channels, all pins, both divided, lock combinations (R2)
        ch2_on = 1'b1; out_cfg = 5'b11111;
        run(100); ch2_locked = 1'b1;
        run(100); ch1_locked = 1'b0;
        run(100); ch1_locked = 1'b1;
        run(200);
        // only channel 2 on (R3, R9)
        ch1_on = 1'b0; run(50); ch2_locked = 1'b0; run(50); ch2_locked = 1'b1;
        // R7: switch pass-through to divide while the output is high
        ch1_on = 1'b1; out_cfg = 5'b11110; run(20);
        for (int k = 0; k < 20 && clk1_dat != 1'b1; k++) @(negedge clk);
        out_cfg = 5'b11111;
        @(negedge clk);
        check(clk1_dat, 0, "R7", "divided output after select change");
        run(200);
        // R7: switch off and on again mid-count
        ch2_on = 1'b0; @(negedge clk); ch2_on = 1'b1; run(200);
        // R8: pins off while channels run
        out_cfg = 5'b00011; run(60);
        out_cfg = 5'b10100; run(60);
        // R4: nothing switched on
        ch1_on = 1'b0; ch2_on = 1'b0; out_cfg = 5'b11111; run(60);
        @(negedge clk);
        check(lock_out, 0, "R4", "lock with no channel on");
        done = 1;
        finish_up();
    end
endmodule